// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder and Mailbox Bridge

This block connects an 8-bit microcontroller working with an external, multiplexed bus to the memories and the reconfigurable fabric of a small board. The high address byte arrives on its own port. The low address byte and the data share a single 8-bit bus. When the address strobe is high, the block captures the low byte. It then decodes the full 16-bit address into active-low selects for an external SRAM and an external EEPROM.

The block also holds six byte-wide registers at the bottom of the page at 0x4000. The host uses them to exchange bytes with the fabric, to drive the fabric's control lines and five status LEDs, and to read back the fabric's status lines. The bus clock and the strobe are sampled on the system clock `clk`. A bus cycle runs from the strobe until the bus clock falls. Register writes commit at that falling edge. Register reads drive the bus only while the bus clock is high.

Top module: `mxbus_bridge`

## Requirements
- R1: The low address byte is taken from `ad_in` on every clock in which `as_strb` is high. It holds its value until the next strobe, whatever `ad_in` does in between.
- R2: While `rst` is high, and after it, the following hold until a write: both memory selects are high, `ad_oe` is low, and `fab_to`, `fab_ctrl` and `led` are zero.
- R3: `sram_cs_n` is low exactly while a bus cycle is live and the address is in 0x2000..0x3FFF.
- R4: `rom_cs_n` is low exactly while a bus cycle is live and the address is in 0x8000..0xFFFF.
- R5: There are six registers, and the low address bits pick among them. Offset 0 is outbound data (read/write). Offset 1 is inbound data (read-only). Offset 2 is control (read/write, low 4 bits). Offset 3 is status (read-only, low 4 bits). Offset 4 is LEDs (read/write, low 5 bits). Offset 5 is scratch (read/write). Unimplemented bits read as zero.
- R6: A write takes effect on the clock in which the bus clock is seen to fall while `rw` is low. The bus must be in a live register cycle at that time. The byte stored is the one on `ad_in` then.
- R7: `ad_oe` is high only while `e_clk` is high, `rw` is high and a live cycle addresses one of the six registers. At all other times it is low. Addresses 0x4006..0x40FF read nothing.
- R8: `fab_ctrl` always equals the control register, and `led` always equals the LED register.
- R9: At most one of these is active at a time: the SRAM select, the EEPROM select and the register window. Addresses outside the three ranges select nothing.
- R10: A read of the inbound or status register returns the `fab_from` or `fab_stat` value sampled on the previous clock.
- R11: A bus cycle ends on the clock after the bus clock falls. After that, no select is active until the next strobe.
- R12: Writes to the read-only offsets 1 and 3, and to offsets 6..255 of the window, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all bus inputs |
| rst | input | 1 | Synchronous reset, active high |
| addr_hi | input | 8 | High address byte from the host |
| ad_in | input | 8 | Multiplexed low-address/data bus, host to block |
| ad_out | output | 8 | Read data driven onto the multiplexed bus |
| ad_oe | output | 1 | Bus drive enable for `ad_out` |
| rw | input | 1 | 1 = read, 0 = write |
| as_strb | input | 1 | Address strobe, high while the low address is on the bus |
| e_clk | input | 1 | Bus clock from the host |
| sram_cs_n | output | 1 | SRAM select, active low |
| rom_cs_n | output | 1 | EEPROM select, active low |
| fab_to | output | 8 | Outbound data register to the fabric |
| fab_from | input | 8 | Inbound data from the fabric |
| fab_ctrl | output | 4 | Fabric control lines |
| fab_stat | input | 4 | Fabric status lines |
| led | output | 5 | Status LED drives |

## Verification
Suppose the latched low byte were corrupted, or were reloaded without a strobe. A wrong memory select would then appear on the clock after the bus data changes. A read in the same cycle would also return the wrong register. A stuck live flag would show as a select that stays low on the clock after the bus clock falls. A misrouted write would appear at `fab_to`, `fab_ctrl` or `led` one clock after the falling bus clock, or later when that register is read back. The reference model in the bench predicts every output each clock, so each of these faults is caught within one clock of the point where it becomes visible.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    localparam int BUS_W    = 8;
    localparam int NUM_REGS = 6;

    typedef logic [2*BUS_W-1:0] haddr_t;
    typedef logic [BUS_W-1:0]   byte_t;

    typedef enum logic [2:0] {
        RI_OUT  = 3'd0,
        RI_IN   = 3'd1,
        RI_CTRL = 3'd2,
        RI_STAT = 3'd3,
        RI_LED  = 3'd4,
        RI_SCR  = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic sram;
        logic rom;
        logic regs;
    } sel_t;

    function automatic logic in_range(haddr_t a, haddr_t lo, haddr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/mxbus_front.sv
module mxbus_front
    import mxbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t ad_in,
    input  logic  as_strb,
    input  logic  e_clk,
    output byte_t addr_lo,
    output logic  live,
    output logic  e_fall
);
    logic e_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lo <= '0;
            live    <= 1'b0;
            e_q     <= 1'b0;
        end else begin
            e_q <= e_clk;
            if (as_strb) begin
                addr_lo <= ad_in;
                live    <= 1'b1;
            end else if (e_q && !e_clk) begin
                live <= 1'b0;
            end
        end
    end

    assign e_fall = e_q & ~e_clk;

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !as_strb |=> $stable(addr_lo));

    assert_cycle_end_R11: assert property (@(posedge clk) disable iff (rst)
        (e_fall && !as_strb) |=> !live);

endmodule

// File: rtl/mxbus_decode.sv
module mxbus_decode
    import mxbus_pkg::*;
#(
    parameter haddr_t SRAM_BASE = 16'h2000,
    parameter haddr_t SRAM_LAST = 16'h3FFF,
    parameter haddr_t ROM_BASE  = 16'h8000,
    parameter haddr_t ROM_LAST  = 16'hFFFF,
    parameter haddr_t REG_BASE  = 16'h4000
)(
    input  haddr_t   addr,
    input  logic     live,
    output sel_t     sel,
    output reg_idx_e idx
);
    localparam haddr_t REG_END = haddr_t'(REG_BASE + haddr_t'(NUM_REGS - 1));

    always_comb begin
        sel.sram = live && in_range(addr, SRAM_BASE, SRAM_LAST);
        sel.rom  = live && in_range(addr, ROM_BASE, ROM_LAST);
        sel.regs = live && in_range(addr, REG_BASE, REG_END);
        idx      = reg_idx_e'(addr[2:0]);
    end

endmodule

// File: rtl/mxbus_regs.sv
module mxbus_regs
    import mxbus_pkg::*;
#(
    parameter int CTRL_W = 4,
    parameter int STAT_W = 4,
    parameter int LED_W  = 5
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_idx_e          idx,
    input  byte_t             din,
    input  byte_t             fab_from,
    input  logic [STAT_W-1:0] fab_stat,
    output byte_t             rdata,
    output byte_t             out_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [LED_W-1:0]  led_q
);
    byte_t             in_q;
    byte_t             scr_q;
    logic [STAT_W-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            ctrl_q <= '0;
            led_q  <= '0;
            scr_q  <= '0;
            in_q   <= '0;
            stat_q <= '0;
        end else begin
            in_q   <= fab_from;
            stat_q <= fab_stat;
            if (wr_en) begin
                case (idx)
                    RI_OUT:  out_q  <= din;
                    RI_CTRL: ctrl_q <= din[CTRL_W-1:0];
                    RI_LED:  led_q  <= din[LED_W-1:0];
                    RI_SCR:  scr_q  <= din;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (idx)
            RI_OUT:  rdata = out_q;
            RI_IN:   rdata = in_q;
            RI_CTRL: rdata = BUS_W'(ctrl_q);
            RI_STAT: rdata = BUS_W'(stat_q);
            RI_LED:  rdata = BUS_W'(led_q);
            RI_SCR:  rdata = scr_q;
            default: rdata = '0;
        endcase
    end

    assert_led_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == RI_LED) |=> (led_q == $past(din[LED_W-1:0])));

    assert_ro_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (idx == RI_IN || idx == RI_STAT)) |=>
            ($stable(out_q) && $stable(ctrl_q) && $stable(led_q) && $stable(scr_q)));

endmodule

// File: rtl/mxbus_bridge.sv
module mxbus_bridge
    import mxbus_pkg::*;
#(
    parameter int     CTRL_W    = 4,
    parameter int     STAT_W    = 4,
    parameter int     LED_W     = 5,
    parameter haddr_t SRAM_BASE = 16'h2000,
    parameter haddr_t SRAM_LAST = 16'h3FFF,
    parameter haddr_t ROM_BASE  = 16'h8000,
    parameter haddr_t ROM_LAST  = 16'hFFFF,
    parameter haddr_t REG_BASE  = 16'h4000
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        addr_hi,
    input  logic [7:0]        ad_in,
    output logic [7:0]        ad_out,
    output logic              ad_oe,
    input  logic              rw,
    input  logic              as_strb,
    input  logic              e_clk,
    output logic              sram_cs_n,
    output logic              rom_cs_n,
    output logic [7:0]        fab_to,
    input  logic [7:0]        fab_from,
    output logic [CTRL_W-1:0] fab_ctrl,
    input  logic [STAT_W-1:0] fab_stat,
    output logic [LED_W-1:0]  led
);
    byte_t    addr_lo;
    logic     live;
    logic     e_fall;
    sel_t     sel;
    reg_idx_e idx;
    byte_t    rdata;
    logic     wr_en;

    mxbus_front u_front (
        .clk     (clk),
        .rst     (rst),
        .ad_in   (ad_in),
        .as_strb (as_strb),
        .e_clk   (e_clk),
        .addr_lo (addr_lo),
        .live    (live),
        .e_fall  (e_fall)
    );

    mxbus_decode #(
        .SRAM_BASE (SRAM_BASE),
        .SRAM_LAST (SRAM_LAST),
        .ROM_BASE  (ROM_BASE),
        .ROM_LAST  (ROM_LAST),
        .REG_BASE  (REG_BASE)
    ) u_decode (
        .addr (haddr_t'({addr_hi, addr_lo})),
        .live (live),
        .sel  (sel),
        .idx  (idx)
    );

    assign wr_en = sel.regs && e_fall && !rw;

    mxbus_regs #(
        .CTRL_W (CTRL_W),
        .STAT_W (STAT_W),
        .LED_W  (LED_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .idx      (idx),
        .din      (ad_in),
        .fab_from (fab_from),
        .fab_stat (fab_stat),
        .rdata    (rdata),
        .out_q    (fab_to),
        .ctrl_q   (fab_ctrl),
        .led_q    (led)
    );

    assign ad_oe     = sel.regs && rw && e_clk;
    assign ad_out    = rdata;
    assign sram_cs_n = ~sel.sram;
    assign rom_cs_n  = ~sel.rom;

    assert_one_select_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~sram_cs_n, ~rom_cs_n, ad_oe}));

    assert_drive_window_R7: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (e_clk && rw));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !live |-> (sram_cs_n && rom_cs_n && !ad_oe));

endmodule

// File: tb/mxbus_bridge_test.sv
module mxbus_bridge_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr_hi = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic       rw = 1'b1;
    logic       as_strb = 1'b0;
    logic       e_clk = 1'b0;
    logic       sram_cs_n, rom_cs_n;
    logic [7:0] fab_to;
    logic [7:0] fab_from = '0;
    logic [3:0] fab_ctrl;
    logic [3:0] fab_stat = '0;
    logic [4:0] led;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    bit         m_live = 0;
    int         m_addr = 0;
    int         m_out = 0, m_ctrl = 0, m_led = 0, m_scr = 0;
    int         m_in = 0, m_stat = 0;

    always #(CLK_P/2) clk = ~clk;

    mxbus_bridge uut (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .rw(rw), .as_strb(as_strb),
        .e_clk(e_clk), .sram_cs_n(sram_cs_n), .rom_cs_n(rom_cs_n),
        .fab_to(fab_to), .fab_from(fab_from), .fab_ctrl(fab_ctrl),
        .fab_stat(fab_stat), .led(led)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    // R10: sampled fabric inputs
    always @(posedge clk) begin
        if (rst) begin
            m_in   <= 0;
            m_stat <= 0;
        end else begin
            m_in   <= int'(fab_from);
            m_stat <= int'(fab_stat);
        end
    end

    function automatic int model_read(int off);
        case (off)
            0: return m_out;
            1: return m_in;
            2: return m_ctrl;
            3: return m_stat;
            4: return m_led;
            5: return m_scr;
            default: return 0;
        endcase
    endfunction

    // per-clock comparison against the model
    always @(posedge clk) begin
        #3;
        if (!rst && !finished) begin
            bit hs, hr, hreg, eoe;
            hs   = m_live && m_addr >= 'h2000 && m_addr <= 'h3FFF;
            hr   = m_live && m_addr >= 'h8000 && m_addr <= 'hFFFF;
            hreg = m_live && m_addr >= 'h4000 && m_addr <= 'h4005;
            eoe  = hreg && rw && e_clk;
            check("R3", "sram_cs_n", int'(sram_cs_n), int'(!hs));
            check("R4", "rom_cs_n", int'(rom_cs_n), int'(!hr));
            check("R7", "ad_oe", int'(ad_oe), int'(eoe));
            if (eoe) check("R5", "read data", int'(ad_out), model_read(m_addr - 'h4000));
            check("R6", "fab_to", int'(fab_to), m_out);
            check("R8", "fab_ctrl", int'(fab_ctrl), m_ctrl);
            check("R8", "led", int'(led), m_led);
        end
    end

    task automatic bus_cycle(input int addr, input bit rd, input int wdata);
        @(negedge clk);
        addr_hi = addr[15:8];
        ad_in   = addr[7:0];
        as_strb = 1'b1;
        e_clk   = 1'b0;
        rw      = rd;
        m_live  = 1;
        m_addr  = addr;
        @(negedge clk);
        as_strb = 1'b0;
        // R1: bus now carries data or junk, latched address must hold
        ad_in   = rd ? 8'h5A : wdata[7:0];
        @(negedge clk);
        e_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        e_clk = 1'b0;
        if (!rd && addr >= 'h4000 && addr <= 'h4005) begin
            case (addr - 'h4000)
                0: m_out  = wdata & 'hFF;
                2: m_ctrl = wdata & 'hF;
                4: m_led  = wdata & 'h1F;
                5: m_scr  = wdata & 'hFF;
                default: ; // R12: read-only offsets
            endcase
        end
        m_live = 0; // R11
        @(negedge clk);
        ad_in = 8'h00;
        @(negedge clk);
    endtask

    // read through the bus and return the value seen while driven
    task automatic bus_read_val(input int addr, output int val, output bit oe);
        @(negedge clk);
        addr_hi = addr[15:8]; ad_in = addr[7:0]; as_strb = 1'b1; rw = 1'b1;
        m_live = 1; m_addr = addr;
        @(negedge clk); as_strb = 1'b0; ad_in = 8'hC3;
        @(negedge clk); e_clk = 1'b1;
        @(negedge clk); #1; val = int'(ad_out); oe = ad_oe;
        @(negedge clk); e_clk = 1'b0; m_live = 0;
        @(negedge clk); ad_in = 8'h00;
        @(negedge clk);
    endtask

    initial begin
        int v;
        bit oe;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2", "sram_cs_n in reset", int'(sram_cs_n), 1);
        check("R2", "rom_cs_n in reset", int'(rom_cs_n), 1);
        check("R2", "ad_oe in reset", int'(ad_oe), 0);
        check("R2", "fab_to in reset", int'(fab_to), 0);
        check("R2", "fab_ctrl in reset", int'(fab_ctrl), 0);
        check("R2", "led in reset", int'(led), 0);
        rst = 1'b0;
        @(negedge clk);

        // R5/R6/R8 writes
        bus_cycle('h4000, 0, 'h3C);
        bus_cycle('h4002, 0, 'hA7);
        bus_cycle('h4004, 0, 'hFF);
        bus_cycle('h4005, 0, 'h96);
        for (int i = 0; i < 6; i++) bus_cycle('h4000 + i, 1, 0);

        // R5 explicit read-back of zero-extended fields
        bus_read_val('h4002, v, oe);
        check("R5", "ctrl read width", v, 'h7);
        bus_read_val('h4004, v, oe);
        check("R5", "led read width", v, 'h1F);

        // R10 fabric inputs
        @(negedge clk); fab_from = 8'hE1; fab_stat = 4'h9;
        bus_cycle('h4001, 1, 0);
        bus_read_val('h4003, v, oe);
        check("R10", "status read", v, 'h9);

        // R12 ignored writes, then read back through the bus
        bus_cycle('h4001, 0, 'h11);
        bus_cycle('h4003, 0, 'h22);
        bus_cycle('h4006, 0, 'h33);
        bus_cycle('h40FF, 0, 'h44);
        bus_read_val('h4000, v, oe);
        check("R12", "outbound after ignored writes", v, 'h3C);
        bus_read_val('h4005, v, oe);
        check("R12", "scratch after ignored writes", v, 'h96);
        bus_read_val('h4006, v, oe);
        check("R7", "no drive at offset 6", int'(oe), 0);

        // R3/R4/R9 memory map edges
        bus_cycle('h2000, 1, 0);
        bus_cycle('h3FFF, 0, 'h12);
        bus_cycle('h1FFF, 1, 0);
        bus_cycle('h4100, 1, 0);
        bus_cycle('h7FFF, 0, 'h34);
        bus_cycle('h8000, 1, 0);
        bus_cycle('hFFFF, 0, 'h56);
        bus_cycle('h0000, 1, 0);

        // R6/R8 second write pattern
        bus_cycle('h4004, 0, 'h0A);
        bus_cycle('h4002, 0, 'h05);
        bus_cycle('h4000, 0, 'hC0);
        bus_read_val('h4004, v, oe);
        check("R8", "led readback", v, 'h0A);

        // R11 selects released after the cycle
        @(negedge clk);
        check("R11", "sram idle", int'(sram_cs_n), 1);
        check("R11", "rom idle", int'(rom_cs_n), 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule